// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus side and the storage of a small serial EEPROM. It holds 256 bytes in internal registers and answers a two-wire serial bus as a slave. SCL and SDA arrive as raw levels. Each passes through a synchronizer and a glitch filter. The block pulls SDA low only through an enable output, and the pad or the bench resolves that into a wired-AND bus. Three strap inputs set the low bits of the bus address, so eight of these devices can share one bus. A write-protect input locks the upper half of the array.

A master selects the device and then writes a word address. It can follow that with one data byte or up to a page of sixteen. It can instead send a repeated start and read from that address, or start a read at once from the current address pointer. Written bytes are gathered in a page buffer and committed together at the stop condition. A busy counter then models the self-timed program cycle. While it runs, the device ignores its own address.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe` low), every array byte reads 0xFF, and the address pointer is 0x00.
- R2: A level change on SCL or SDA that lasts fewer than `FILT_LEN` clock cycles is ignored and does not disturb a transfer.
- R3: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start at any point, including partway through a byte, aborts that byte and begins a new address phase.
- R4: The address byte is sent MSB first as 1010, then strap[2:0], then a read/write bit (1 = read). A byte with any other type or strap value gets no acknowledge, and the slave stays silent until the next start.
- R5: Each byte the slave accepts is acknowledged by SDA held low for the whole ninth SCL high period.
- R6: A write of address byte, word address and one data byte, followed by a stop, stores the data byte at that word address.
- R7: In a write, successive data bytes go to successive addresses. Only the low 4 address bits advance, and they wrap inside the 16-byte page. All the bytes are committed together at the stop.
- R8: When `wp_i` is high, data bytes aimed at addresses 0x80 to 0xFF are acknowledged but not stored. Addresses 0x00 to 0x7F stay writable.
- R9: A stop that ends a write with at least one data byte starts a busy period of `WR_CYCLES` clocks. During that period the slave does not acknowledge its own address.
- R10: A read returns the byte at the address pointer and then advances the pointer. A written word address sets the pointer, so a repeated start after it performs a random read.
- R11: While the master acknowledges, a read continues with the next address. The full 8-bit pointer wraps from 0xFF to 0x00.
- R12: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until a start or a stop.
- R13: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock level |
| sda_i | input | 1 | Raw serial data level as seen on the bus |
| strap_i | input | 3 | Address strap bits compared with the address byte |
| wp_i | input | 1 | Write protect for addresses 0x80 to 0xFF |
| sda_oe | output | 1 | High to pull SDA low, low to release it |

## Verification
Several corners get directed tests. One is a page write that starts near the end of a page. A design that carried into the upper address bits would scatter the bytes onto the next page. Another is a sequential read across 0xFF: a pointer that saturates, or wraps only inside the page, returns the wrong bytes. A repeated start in the middle of a byte must throw away the partial bits, and an abort that goes wrong would store data at a stale address. Two-cycle glitches on SCL and on SDA during a write check the filter, because an unfiltered design would count an extra bit or see a false start. Random single-byte writes and reads are then checked against a model of the array. A monitor also catches any drive change while SCL is high.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_ACK_DEV,
        S_WADDR,
        S_ACK_WADDR,
        S_WDATA,
        S_ACK_WDATA,
        S_RDATA,
        S_RACK,
        S_RNEXT
    } slave_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_locked(input logic wp, input logic top_bit);
        return wp & top_bit;
    endfunction

endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic pin_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            pin_o  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            if (sync_q[1] == pin_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                pin_o <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: output only moves after the synchronized input held a new level
    a_r2_filtered_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_o) |-> (pin_o == $past(sync_q[1])));
endmodule

// File: rtl/bus_events.sv
module bus_events
    import eeprom_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start = scl & scl_q & sda_q & ~sda;
        ev.stop  = scl & scl_q & ~sda_q & sda;
        ev.rise  = scl & ~scl_q;
        ev.fall  = ~scl & scl_q;
    end

    // R3: a start and a stop can never be reported together
    a_r3_exclusive_events: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/slave_core.sv
module slave_core
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BW     = $clog2(WR_CYCLES + 1);

    slave_state_t          state;
    logic [3:0]            bitcnt;
    logic [7:0]            shreg;
    logic [ADDR_W-1:0]     ptr;
    logic [7:0]            mem   [DEPTH];
    logic [7:0]            pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic                  wrote;
    logic [BW-1:0]         busy_cnt;
    logic                  busy;
    logic                  dev_hit;

    assign busy    = (busy_cnt != '0);
    assign dev_hit = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            pvalid   <= '0;
            wrote    <= 1'b0;
            busy_cnt <= '0;
            sda_oe   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;

            if (ev.start) begin
                state  <= S_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                pvalid <= '0;
                wrote  <= 1'b0;
            end else if (ev.stop) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
                if (wrote) begin
                    for (int i = 0; i < PAGE_BYTES; i++)
                        if (pvalid[i])
                            mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
                    busy_cnt <= BW'(WR_CYCLES);
                end
                pvalid <= '0;
                wrote  <= 1'b0;
            end else begin
                unique case (state)
                    S_DEV, S_WADDR, S_WDATA: begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == S_DEV) begin
                                if (dev_hit) begin
                                    sda_oe <= 1'b1;
                                    state  <= S_ACK_DEV;
                                end else begin
                                    state  <= S_IDLE;
                                end
                            end else if (state == S_WADDR) begin
                                ptr    <= shreg[ADDR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= S_ACK_WADDR;
                            end else begin
                                if (!addr_locked(wp_i, ptr[ADDR_W-1])) begin
                                    pbuf[ptr[PAGE_W-1:0]]   <= shreg;
                                    pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
                                end
                                wrote  <= 1'b1;
                                ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                sda_oe <= 1'b1;
                                state  <= S_ACK_WDATA;
                            end
                        end
                    end
                    S_ACK_DEV: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (shreg[0]) begin
                                shreg  <= mem[ptr];
                                sda_oe <= ~mem[ptr][7];
                                ptr    <= ptr + 1'b1;
                                state  <= S_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= S_WADDR;
                            end
                        end
                    end
                    S_ACK_WADDR, S_ACK_WDATA: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            state  <= S_WDATA;
                        end
                    end
                    S_RDATA: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= S_RACK;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    S_RACK: begin
                        if (ev.rise) state <= sda_lvl ? S_IDLE : S_RNEXT;
                    end
                    S_RNEXT: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            shreg  <= mem[ptr];
                            sda_oe <= ~mem[ptr][7];
                            ptr    <= ptr + 1'b1;
                            state  <= S_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a start re-arms address reception with SDA released
    a_r3_start_rearms: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == S_DEV && bitcnt == 4'd0 && !sda_oe));
    // R3: a stop always returns to idle
    a_r3_stop_idles: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == S_IDLE));
    // R9: no address acknowledge while the program cycle runs
    a_r9_silent_busy: assert property (@(posedge clk) disable iff (rst)
        (state == S_DEV && ev.fall && bitcnt == 4'd8 && busy) |=> !sda_oe);
    // R9: busy counter never exceeds the programmed cycle length
    a_r9_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= BW'(WR_CYCLES));
    // R13: the drive is only asserted while SCL is low
    a_r13_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);
    // R12: after a master NACK the slave stays released
    a_r12_nack_release: assert property (@(posedge clk) disable iff (rst)
        (state == S_RACK && ev.rise && sda_lvl) |=> (!sda_oe && state == S_IDLE));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int FILT_LEN   = 4,
    parameter int WR_CYCLES  = 1250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe
);
    logic [1:0] raw_pins;
    logic [1:0] clean_pins;
    bus_ev_t    ev;

    assign raw_pins = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .pin_i(raw_pins[g]),
            .pin_o(clean_pins[g])
        );
    end

    bus_events u_ev (
        .clk(clk),
        .rst(rst),
        .scl(clean_pins[1]),
        .sda(clean_pins[0]),
        .ev (ev)
    );

    slave_core #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .WR_CYCLES (WR_CYCLES)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .scl_lvl(clean_pins[1]),
        .sda_lvl(clean_pins[0]),
        .strap_i(strap_i),
        .wp_i   (wp_i),
        .sda_oe (sda_oe)
    );
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
    localparam int Q   = 12;
    localparam int WRC = 1500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int hi_viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [256];

    assign sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_eeprom_slave #(.FILT_LEN(4), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_i(strap), .wp_i(wp), .sda_oe(sda_oe)
    );

    // R13 monitor: drive must not move while raw SCL is high
    always @(posedge clk) begin
        if (!rst && scl_m && (sda_oe != prev_oe)) hi_viol++;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] page_next(input logic [7:0] a);
        return {a[7:4], a[3:0] + 4'd1};
    endfunction

    function automatic logic locked(input logic w, input logic [7:0] a);
        return w && a[7];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q); wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, input logic glitch, output logic ack);
        for (int i = 0; i < 8; i++) begin
            sda_m = b[7-i];
            if (glitch && i == 3) begin
                wq(4); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q-6);
                scl_m = 1'b1; wq(4); sda_m = 1'b0; wq(2); sda_m = b[7-i]; wq(Q-6);
            end else begin
                wq(Q); scl_m = 1'b1; wq(Q);
            end
            wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        ack = ~sda_bus;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            d[7-i] = sda_bus;
            wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = ~mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic write_seq(input logic [7:0] a, input logic [7:0] d[$], input logic gl);
        logic ack;
        logic [7:0] p;
        bstart();
        wbyte({4'b1010, strap, 1'b0}, 1'b0, ack); chk(ack, "R5 dev ack (write)", ack, 1);
        wbyte(a, 1'b0, ack); chk(ack, "R5 word addr ack", ack, 1);
        p = a;
        foreach (d[k]) begin
            wbyte(d[k], gl, ack);
            chk(ack, "R8/R5 data ack", ack, 1);
            if (!locked(wp, p)) model[p] = d[k];
            p = page_next(p);
        end
        bstop();
    endtask

    task automatic set_ptr_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic [7:0] p;
        bstart();
        wbyte({4'b1010, strap, 1'b0}, 1'b0, ack);
        wbyte(a, 1'b0, ack);
        bstart();
        wbyte({4'b1010, strap, 1'b1}, 1'b0, ack); chk(ack, "R10 read dev ack", ack, 1);
        p = a;
        for (int k = 0; k < n; k++) begin
            rbyte(k != n-1, d);
            chk(d == model[p], req, d, model[p]);
            p = p + 8'd1;
        end
        bstop();
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk); wd++;
            if (wd > 190000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<190000", wd);
                $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        logic [7:0] q[$];
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        wq(5); rst = 1'b0; wq(5);
        chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R1/R10: current-address read from reset pointer 0
        bstart();
        wbyte({4'b1010, strap, 1'b1}, 1'b0, ack); chk(ack, "R4 matching address acked", ack, 1);
        rbyte(1'b0, d); chk(d == 8'hFF, "R1 erased content at 0x00", d, 8'hFF);
        bstop();

        // R6 single byte write, R9 busy
        q = '{8'hA5}; write_seq(8'h10, q, 1'b0);
        bstart();
        wbyte({4'b1010, strap, 1'b0}, 1'b0, ack); chk(!ack, "R9 no ack while busy", ack, 0);
        bstop();
        wq(WRC + 50);
        set_ptr_read(8'h10, 1, "R6 byte write readback");
        bstart();
        wbyte({4'b1010, strap, 1'b1}, 1'b0, ack);
        rbyte(1'b0, d); chk(d == model[8'h11], "R10 pointer advanced after read", d, model[8'h11]);
        bstop();

        // R7 page wrap
        q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        write_seq(8'h2C, q, 1'b0); wq(WRC + 50);
        chk(model[8'h20] == 8'h05 && model[8'h30] == 8'hFF, "R7 model wrap sanity", model[8'h20], 8'h05);
        set_ptr_read(8'h20, 17, "R7/R11 page wrap readback");

        // R8 write protect
        wp = 1'b1;
        q = '{8'h3C, 8'h3D}; write_seq(8'h90, q, 1'b0); wq(WRC + 50);
        q = '{8'h44}; write_seq(8'h40, q, 1'b0); wq(WRC + 50);
        wp = 1'b0;
        set_ptr_read(8'h90, 2, "R8 protected bytes unchanged");
        set_ptr_read(8'h40, 1, "R8 lower half writable");

        // R11 wrap 0xFF -> 0x00
        q = '{8'hE1}; write_seq(8'hFF, q, 1'b0); wq(WRC + 50);
        q = '{8'h0E}; write_seq(8'h00, q, 1'b0); wq(WRC + 50);
        set_ptr_read(8'hFE, 4, "R11 sequential wrap");

        // R12 NACK then dummy byte sees released bus
        bstart();
        wbyte({4'b1010, strap, 1'b1}, 1'b0, ack);
        rbyte(1'b0, d);
        rbyte(1'b0, d); chk(d == 8'hFF, "R12 released after NACK", d, 8'hFF);
        bstop();

        // R4 mismatches
        bstart();
        wbyte({4'b1010, 3'b000, 1'b0}, 1'b0, ack); chk(!ack, "R4 wrong strap no ack", ack, 0);
        wbyte(8'h00, 1'b0, ack); chk(!ack, "R4 silent until start", ack, 0);
        bstop();
        bstart();
        wbyte({4'b1011, strap, 1'b1}, 1'b0, ack); chk(!ack, "R4 wrong type no ack", ack, 0);
        bstop();

        // R3 repeated start mid-byte
        bstart();
        wbyte({4'b1010, strap, 1'b0}, 1'b0, ack);
        wbyte(8'h50, 1'b0, ack);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
        bstart();
        wbyte({4'b1010, strap, 1'b0}, 1'b0, ack); chk(ack, "R3 restart address acked", ack, 1);
        wbyte(8'h51, 1'b0, ack);
        wbyte(8'h77, 1'b0, ack);
        bstop(); model[8'h51] = 8'h77; wq(WRC + 50);
        set_ptr_read(8'h50, 2, "R3 aborted byte discarded");

        // R2 glitches on SCL and SDA
        q = '{8'h5A}; write_seq(8'h33, q, 1'b1); wq(WRC + 50);
        set_ptr_read(8'h33, 1, "R2 glitches rejected");

        // random single writes and reads
        for (int it = 0; it < 10; it++) begin
            logic [7:0] ra;
            ra = 8'($urandom);
            q = '{8'($urandom)};
            write_seq(ra, q, 1'b0); wq(WRC + 50);
            set_ptr_read(ra, 1, "R6 random write readback");
        end

        chk(hi_viol == 0, "R13 drive changes only with SCL low", hi_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule